// File: doc/BRIEF.md
# Upward-Growing Byte Stack Controller

This block keeps a last-in, first-out stack inside its own 256-byte data RAM. An 8-bit stack pointer marks the most recently filled location. The stack grows toward higher addresses, so a push moves the pointer up before it writes and a pop reads before it moves the pointer down. Byte push and byte pop each take one clock cycle. A call-save stores a 16-bit return address as two bytes, low byte first. A return-restore reads those two bytes back, high byte first, and presents the rebuilt address. Each 16-bit operation takes two clock cycles, because the RAM performs one access per cycle.

Software can overwrite the pointer directly, for example to move the stack out of a low region of RAM that is reserved for other use. Every accepted operation, including a direct load, gives a one-cycle done strobe. A busy flag covers the second cycle of a 16-bit operation, and the block ignores every request while busy is high. The pointer arithmetic wraps modulo 256 and no trap exists for overflow or underflow. The asynchronous reset is synchronised inside the block before it is released.

Top module: `byte_stack_ctl`

## Requirements
- R1: After reset the stack pointer reads 07H, and busy and done are both low.
- R2: An accepted push sets the pointer to SP+1 and writes push_data at that new address. SP and done show the result in the cycle after acceptance, and the first push after reset lands at 08H.
- R3: An accepted pop reads the byte at the current SP and then sets the pointer to SP-1. pop_data and done are valid in the cycle after acceptance.
- R4: Bytes come back in the reverse of the order in which they were pushed, and this holds even when 16-bit frames are interleaved with byte pushes.
- R5: A call-save writes ret_addr_in[7:0] at SP+1 and ret_addr_in[15:8] at SP+2. busy is high in the cycle after acceptance. In the cycle after that, done is high, busy is low and SP equals the starting SP+2. Starting from SP=07H with 0126H, the result is 26H at 08H, 01H at 09H and SP=09H.
- R6: A return-restore takes the high byte from SP and the low byte from SP-1. busy is high for one cycle. When done pulses, SP equals the starting SP-2 and ret_addr_out holds {high, low}.
- R7: An accepted direct load sets SP to sp_load_val in the cycle after acceptance and pulses done.
- R8: When several requests arrive together while idle, one is accepted in the fixed priority load > call-save > return-restore > push > pop. The others have no effect on SP or on RAM.
- R9: While busy is high, every request, including a direct load, is ignored.
- R10: Pointer arithmetic wraps: a push from FFH leaves SP=00H, and a pop from 00H leaves SP=FFH.
- R11: With no request, SP holds its value and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Byte push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Byte pop request |
| call_req | input | 1 | Call-save request (stack ret_addr_in) |
| ret_addr_in | input | 16 | Return address to stack |
| ret_req | input | 1 | Return-restore request |
| sp_load | input | 1 | Direct stack pointer load |
| sp_load_val | input | 8 | Value for the direct load |
| sp | output | 8 | Current stack pointer |
| pop_data | output | 8 | Byte read by the last pop |
| ret_addr_out | output | 16 | Address rebuilt by the last return-restore |
| busy | output | 1 | Second cycle of a 16-bit operation in progress |
| done | output | 1 | One-cycle strobe when an operation completes |

## Verification
Byte push, byte pop and direct load complete at the first clock edge after the cycle in which they are accepted, so SP, done and pop_data are checked half a cycle after that edge. Call-save and return-restore complete one edge later. The bench checks that busy is high and done is low after the first edge, and checks SP, done and ret_addr_out after the second edge. Requests are driven on falling edges and results are sampled on falling edges, so every check falls at a fixed edge count from its stimulus. To show that a losing or blocked request had no effect, the bench later pops or restores the location that request would have overwritten.

// File: rtl/byte_stack_ctl_pkg.sv
package byte_stack_ctl_pkg;

  // Pointer update selected by the sequencer each cycle
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_INC  = 2'd1,
    SP_DEC  = 2'd2,
    SP_LOAD = 2'd3
  } sp_op_e;

  // Second-cycle phase of a 16-bit operation
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CALL_HI = 2'd1,
    PH_RET_LO  = 2'd2
  } phase_e;

endpackage

// File: rtl/stack_rst_sync.sv
module stack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
  import byte_stack_ctl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_VAL = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_op_e            op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] sp_plus,
  output logic [ADDR_W-1:0] sp_minus
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_d;

  // Plain modulo arithmetic: no overflow or underflow trap
  assign sp_plus  = sp_q + ONE;
  assign sp_minus = sp_q - ONE;

  always_comb begin
    sp_d = sp_q;
    case (op)
      SP_INC:  sp_d = sp_plus;
      SP_DEC:  sp_d = sp_minus;
      SP_LOAD: sp_d = load_val;
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= RESET_VAL;
    else        sp_q <= sp_d;
  end

endmodule

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage array: no reset, one access per cycle
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Registered read port with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import byte_stack_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_req,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                pop_req,
  input  logic                call_req,
  input  logic [2*DATA_W-1:0] ret_addr_in,
  input  logic                ret_req,
  input  logic                sp_load,
  input  logic [DATA_W-1:0]   ram_rdata,
  output sp_op_e              sp_op,
  output logic                addr_sel_inc,
  output logic                ram_we,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic                ram_re,
  output logic [2*DATA_W-1:0] ret_addr,
  output logic                busy,
  output logic                done
);

  phase_e            phase_q, phase_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] call_hi_q, call_hi_d;
  logic [DATA_W-1:0] ret_hi_q;
  logic              ret_hi_en;

  always_comb begin
    sp_op        = SP_HOLD;
    addr_sel_inc = 1'b0;
    ram_we       = 1'b0;
    ram_re       = 1'b0;
    ram_wdata    = push_data;
    phase_d      = phase_q;
    done_d       = 1'b0;
    call_hi_d    = call_hi_q;
    ret_hi_en    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        // Fixed priority: load, call-save, return-restore, push, pop
        if (sp_load) begin
          sp_op  = SP_LOAD;
          done_d = 1'b1;
        end else if (call_req) begin
          sp_op        = SP_INC;
          addr_sel_inc = 1'b1;
          ram_we       = 1'b1;
          ram_wdata    = ret_addr_in[DATA_W-1:0];
          call_hi_d    = ret_addr_in[2*DATA_W-1:DATA_W];
          phase_d      = PH_CALL_HI;
        end else if (ret_req) begin
          sp_op   = SP_DEC;
          ram_re  = 1'b1;
          phase_d = PH_RET_LO;
        end else if (push_req) begin
          sp_op        = SP_INC;
          addr_sel_inc = 1'b1;
          ram_we       = 1'b1;
          done_d       = 1'b1;
        end else if (pop_req) begin
          sp_op  = SP_DEC;
          ram_re = 1'b1;
          done_d = 1'b1;
        end
      end
      PH_CALL_HI: begin
        sp_op        = SP_INC;
        addr_sel_inc = 1'b1;
        ram_we       = 1'b1;
        ram_wdata    = call_hi_q;
        done_d       = 1'b1;
        phase_d      = PH_IDLE;
      end
      PH_RET_LO: begin
        sp_op     = SP_DEC;
        ram_re    = 1'b1;
        ret_hi_en = 1'b1;   // read register still holds the high byte
        done_d    = 1'b1;
        phase_d   = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      done_q    <= 1'b0;
      call_hi_q <= '0;
      ret_hi_q  <= '0;
    end else begin
      phase_q   <= phase_d;
      done_q    <= done_d;
      call_hi_q <= call_hi_d;
      if (ret_hi_en) ret_hi_q <= ram_rdata;
    end
  end

  assign ret_addr = {ret_hi_q, ram_rdata};
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/byte_stack_ctl.sv
module byte_stack_ctl
  import byte_stack_ctl_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_req,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                pop_req,
  input  logic                call_req,
  input  logic [2*DATA_W-1:0] ret_addr_in,
  input  logic                ret_req,
  input  logic                sp_load,
  input  logic [ADDR_W-1:0]   sp_load_val,
  output logic [ADDR_W-1:0]   sp,
  output logic [DATA_W-1:0]   pop_data,
  output logic [2*DATA_W-1:0] ret_addr_out,
  output logic                busy,
  output logic                done
);

  logic              rst_int_n;
  sp_op_e            sp_op;
  logic [ADDR_W-1:0] sp_plus, sp_minus, ram_addr;
  logic              addr_sel_inc, ram_we, ram_re;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  stack_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  stack_ptr #(.ADDR_W(ADDR_W), .RESET_VAL(SP_RESET)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op       (sp_op),
    .load_val (sp_load_val),
    .sp_q     (sp),
    .sp_plus  (sp_plus),
    .sp_minus (sp_minus)
  );

  stack_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .push_req     (push_req),
    .push_data    (push_data),
    .pop_req      (pop_req),
    .call_req     (call_req),
    .ret_addr_in  (ret_addr_in),
    .ret_req      (ret_req),
    .sp_load      (sp_load),
    .ram_rdata    (ram_rdata),
    .sp_op        (sp_op),
    .addr_sel_inc (addr_sel_inc),
    .ram_we       (ram_we),
    .ram_wdata    (ram_wdata),
    .ram_re       (ram_re),
    .ret_addr     (ret_addr_out),
    .busy         (busy),
    .done         (done)
  );

  // Writes go to the pre-incremented address; reads use the current top
  assign ram_addr = addr_sel_inc ? sp_plus : sp;

  stack_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr    (ram_addr),
    .we      (ram_we),
    .wdata   (ram_wdata),
    .re      (ram_re),
    .rdata_q (ram_rdata)
  );

  assign pop_data = ram_rdata;

  // sp_minus is only needed by the pointer itself
  logic unused_minus;
  assign unused_minus = ^sp_minus;

endmodule

// File: rtl/byte_stack_ctl_chk.sv
module byte_stack_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              call_req,
  input logic              ret_req,
  input logic              sp_load,
  input logic [ADDR_W-1:0] sp_load_val,
  input logic [ADDR_W-1:0] sp,
  input logic              busy,
  input logic              done
);

  logic idle, load_acc, call_acc, ret_acc, push_acc, pop_acc, none_acc;

  assign idle     = rst_n && !busy;
  assign load_acc = idle && sp_load;
  assign call_acc = idle && !sp_load && call_req;
  assign ret_acc  = idle && !sp_load && !call_req && ret_req;
  assign push_acc = idle && !sp_load && !call_req && !ret_req && push_req;
  assign pop_acc  = idle && !sp_load && !call_req && !ret_req && !push_req && pop_req;
  assign none_acc = idle && !sp_load && !call_req && !ret_req && !push_req && !pop_req;

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> (sp == ADDR_W'($past(sp) + 1'b1)) && done && !busy);

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |=> (sp == ADDR_W'($past(sp) - 1'b1)) && done && !busy);

  // R5
  call_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_acc |=> busy && !done && (sp == ADDR_W'($past(sp) + 1'b1)));

  // R5
  call_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(call_acc, 2) |-> done && !busy && (sp == ADDR_W'($past(sp, 2) + 2'd2)));

  // R6
  ret_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_acc |=> busy && !done && (sp == ADDR_W'($past(sp) - 1'b1)));

  // R6
  ret_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_acc, 2) |-> done && !busy && (sp == ADDR_W'($past(sp, 2) - 2'd2)));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> (sp == $past(sp_load_val)) && done);

  // R9
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && done);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_acc |=> $stable(sp) && !done);

endmodule

bind byte_stack_ctl byte_stack_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .sp_load     (sp_load),
  .sp_load_val (sp_load_val),
  .sp          (sp),
  .busy        (busy),
  .done        (done)
);

// File: tb/byte_stack_ctl_bench.sv
`timescale 1ns/1ps
module byte_stack_ctl_bench;

  localparam logic [2:0] OP_PUSH = 3'd0;
  localparam logic [2:0] OP_POP  = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_LOAD = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] arg;
    logic [7:0]  sp;
    logic [15:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{OP_CALL, 16'h0126, 8'h09, 16'h0000, 4'd5},  // R5 example frame
    '{OP_PUSH, 16'h00AA, 8'h0A, 16'h0000, 4'd2},  // R2
    '{OP_POP,  16'h0000, 8'h09, 16'h00AA, 4'd3},  // R3
    '{OP_RET,  16'h0000, 8'h07, 16'h0126, 4'd6},  // R6
    '{OP_LOAD, 16'h0008, 8'h08, 16'h0000, 4'd7},  // R7
    '{OP_POP,  16'h0000, 8'h07, 16'h0026, 4'd5},  // R5 low byte at 08H
    '{OP_LOAD, 16'h0009, 8'h09, 16'h0000, 4'd7},  // R7
    '{OP_POP,  16'h0000, 8'h08, 16'h0001, 4'd5},  // R5 high byte at 09H
    '{OP_LOAD, 16'h002F, 8'h2F, 16'h0000, 4'd7},  // R7 relocate
    '{OP_PUSH, 16'h0011, 8'h30, 16'h0000, 4'd4},  // R4
    '{OP_PUSH, 16'h0022, 8'h31, 16'h0000, 4'd4},  // R4
    '{OP_CALL, 16'hBEEF, 8'h33, 16'h0000, 4'd4},  // R4
    '{OP_RET,  16'h0000, 8'h31, 16'hBEEF, 4'd4},  // R4
    '{OP_POP,  16'h0000, 8'h30, 16'h0022, 4'd4},  // R4
    '{OP_POP,  16'h0000, 8'h2F, 16'h0011, 4'd4},  // R4
    '{OP_LOAD, 16'h00FE, 8'hFE, 16'h0000, 4'd7},  // R7
    '{OP_CALL, 16'h1234, 8'h00, 16'h0000, 4'd10}, // R10 FFH->00H
    '{OP_RET,  16'h0000, 8'hFE, 16'h1234, 4'd10}, // R10 00H->FFH
    '{OP_LOAD, 16'h0000, 8'h00, 16'h0000, 4'd7},  // R7
    '{OP_POP,  16'h0000, 8'hFF, 16'h0012, 4'd10}, // R10
    '{OP_POP,  16'h0000, 8'hFE, 16'h0034, 4'd10}  // R10
  };

  logic        clk, rst_n;
  logic        push_req, pop_req, call_req, ret_req, sp_load;
  logic [7:0]  push_data, sp_load_val, sp, pop_data;
  logic [15:0] ret_addr_in, ret_addr_out;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  byte_stack_ctl u_byte_stack_ctl (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .call_req(call_req), .ret_addr_in(ret_addr_in), .ret_req(ret_req),
    .sp_load(sp_load), .sp_load_val(sp_load_val),
    .sp(sp), .pop_data(pop_data), .ret_addr_out(ret_addr_out),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; sp_load = 0;
  endtask

  task automatic set_op(input logic [2:0] op, input logic [15:0] arg);
    case (op)
      OP_PUSH: begin push_req = 1; push_data = arg[7:0]; end
      OP_POP:  pop_req = 1;
      OP_CALL: begin call_req = 1; ret_addr_in = arg; end
      OP_RET:  ret_req = 1;
      default: begin sp_load = 1; sp_load_val = arg[7:0]; end
    endcase
  endtask

  // Drive one op at a falling edge; return at the falling edge where it has completed
  task automatic run_op(input logic [2:0] op, input logic [15:0] arg,
                        input logic [7:0] esp, input logic [15:0] eval, input string tag);
    @(negedge clk); set_op(op, arg);
    @(negedge clk); clear_in();
    if (op == OP_CALL || op == OP_RET) begin
      chk({tag, " busy mid"}, {15'd0, busy}, 16'd1);
      chk({tag, " done mid"}, {15'd0, done}, 16'd0);
      @(negedge clk);
      chk({tag, " busy end"}, {15'd0, busy}, 16'd0);
    end
    chk({tag, " done"}, {15'd0, done}, 16'd1);
    chk({tag, " sp"}, {8'd0, sp}, {8'd0, esp});
    if (op == OP_POP) chk({tag, " pop_data"}, {8'd0, pop_data}, eval);
    if (op == OP_RET) chk({tag, " ret_addr"}, ret_addr_out, eval);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    push_data = 0; sp_load_val = 0; ret_addr_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", {8'd0, sp}, 16'h0007);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    // R11 idle hold
    repeat (3) @(negedge clk);
    chk("R11 sp", {8'd0, sp}, 16'h0007);
    chk("R11 done", {15'd0, done}, 16'd0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].op, VECS[i].arg, VECS[i].sp, VECS[i].val,
             $sformatf("R%0d vec%0d", VECS[i].req, i));

    // R8 load beats push: the push would have written 41H
    run_op(OP_LOAD, 16'h0040, 8'h40, 16'h0, "R8 setup");
    run_op(OP_PUSH, 16'h00A5, 8'h41, 16'h0, "R8 setup");
    run_op(OP_POP,  16'h0000, 8'h40, 16'h00A5, "R8 setup");
    @(negedge clk); sp_load = 1; sp_load_val = 8'h50; push_req = 1; push_data = 8'h3C;
    @(negedge clk); clear_in();
    chk("R8 load wins sp", {8'd0, sp}, 16'h0050);
    run_op(OP_LOAD, 16'h0041, 8'h41, 16'h0, "R8 reload");
    run_op(OP_POP,  16'h0000, 8'h40, 16'h00A5, "R8 push ignored");

    // R8 call beats return-restore
    @(negedge clk); call_req = 1; ret_addr_in = 16'h7788; ret_req = 1;
    @(negedge clk); clear_in();
    chk("R8 call wins busy", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R8 call wins sp", {8'd0, sp}, 16'h0042);
    // R8 return-restore beats push
    @(negedge clk); ret_req = 1; push_req = 1; push_data = 8'h99;
    @(negedge clk); clear_in();
    @(negedge clk);
    chk("R8 ret wins sp", {8'd0, sp}, 16'h0040);
    chk("R8 ret wins addr", ret_addr_out, 16'h7788);
    // R8 push beats pop
    @(negedge clk); push_req = 1; push_data = 8'h6E; pop_req = 1;
    @(negedge clk); clear_in();
    chk("R8 push wins sp", {8'd0, sp}, 16'h0041);
    run_op(OP_POP, 16'h0000, 8'h40, 16'h006E, "R8 push wins data");

    // R9 requests while busy are ignored
    @(negedge clk); call_req = 1; ret_addr_in = 16'hCAFE;
    @(negedge clk); clear_in(); push_req = 1; push_data = 8'h12; sp_load = 1; sp_load_val = 8'h10;
    @(negedge clk); clear_in();
    chk("R9 sp after busy", {8'd0, sp}, 16'h0042);
    chk("R9 done", {15'd0, done}, 16'd1);
    run_op(OP_RET, 16'h0000, 8'h40, 16'hCAFE, "R9 frame intact");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule